// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block drives one complete low-speed packet onto a differential D+/D- line pair. Software or an upstream engine fills a byte buffer whose first entry is the sync byte. It then strobes a start request together with a byte count. The transmitter fetches the bytes through a read port that returns data combinationally. It serializes each byte least significant bit first using NRZI coding, and it inserts stuffed zeros where a long run of ones would otherwise leave the line without transitions. It then signals end of packet, hands the bus back and pulses a completion flag.

All line activity is paced by a one-cycle bit-rate enable, so the core clock may run at any multiple of the line rate. The block also owns the active device address. A pending address presented at its input is adopted only when a data packet (more than two bytes) completes. A two-byte handshake reply (sync plus PID) leaves the address alone, so an address change takes effect only after the status data has gone out.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset the drivers are disabled (`oe_o`=0), both lines read 0, `done_o` is 0 and `dev_addr_o` is 0.
- R2: On the clock edge that accepts a start request, the drivers are enabled and the line shows J ({D+,D-} = 2'b01) before any bit is sent.
- R3: Buffer bytes 0 to count-1 are sent in address order, each bit 0 first. A 0 bit toggles the line between J (2'b01) and K (2'b10), and a 1 bit leaves it unchanged. Each line symbol appears on the clock edge that samples a `tick_i` pulse.
- R4: After six consecutive 1 bits on the wire, one extra tick sends a stuffed toggle. The run count restarts on every 0, real or stuffed, and starts at zero for each packet. A run of six that completes on the final data bit is also followed by a stuffed toggle.
- R5: After the last bit, the line shows SE0 (2'b00) for two ticks and then J for one tick. On the following tick the drivers are disabled and both outputs go to 0.
- R6: `done_o` is high for exactly one clock, on the edge that disables the drivers.
- R7: When a packet of more than 2 bytes ends, `dev_addr_o` takes the value of `new_addr_i` on the edge that raises `done_o`. A 2-byte packet leaves `dev_addr_o` unchanged.
- R8: A start request that arrives while a packet is in progress is ignored. The running packet is unaffected, and no second packet follows.
- R9: A start request with a count below 2 or above 12 is ignored: the drivers stay disabled and `done_o` stays low.
- R10: While the drivers are enabled, the line outputs change only on edges that sample `tick_i` high, apart from the start edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send the buffered packet |
| len_i | input | 4 | Byte count including the sync byte (2 to 12) |
| tick_i | input | 1 | One-cycle bit-rate enable |
| rd_addr_o | output | 4 | Buffer byte address being serialized |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o` (combinational) |
| new_addr_i | input | 7 | Pending device address |
| dp_o | output | 1 | D+ line value |
| dm_o | output | 1 | D- line value |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-clock completion pulse |
| dev_addr_o | output | 7 | Active device address |

## Verification
A wrong bit or byte counter shows up as a corrupted symbol within a few ticks of the error. The bench compares every line symbol against an independently built NRZI and stuffing model, so the first wrong toggle is caught on the tick where it appears. A stuffing run counter that is off by one surfaces only once six ones meet, so the bench uses all-ones bytes and a packet whose final run ends exactly at six. Faults in the end-of-packet sequencer, the busy guard and the address commit appear at the release tick or in the idle cycles after it: a missing or doubled done pulse, drivers that stay on, or an address that moves after a handshake.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_SE0A,
    ST_SE0B,
    ST_IDLEJ
  } tx_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACQUIRE,
    OP_DATA,
    OP_STUFF,
    OP_SE0,
    OP_IDLE,
    OP_RELEASE
  } line_op_e;

endpackage

// File: rtl/usb_ls_tx_line.sv
module usb_ls_tx_line
  import usb_ls_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  line_op_e op_i,
  input  logic     bit_i,
  output logic     stuff_due_o,
  output logic     dp_o,
  output logic     dm_o,
  output logic     oe_o
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic             dp_q, dm_q, oe_q;
  logic             dp_d, dm_d, oe_d;
  logic [RUN_W-1:0] run_q, run_d;

  // line encoder: NRZI toggle, stuff run tracking, EOP levels
  always_comb begin
    dp_d  = dp_q;
    dm_d  = dm_q;
    oe_d  = oe_q;
    run_d = run_q;
    unique case (op_i)
      OP_ACQUIRE: begin
        oe_d  = 1'b1;
        dp_d  = 1'b0;
        dm_d  = 1'b1;
        run_d = '0;
      end
      OP_DATA: begin
        if (bit_i) begin
          run_d = run_q + RUN_W'(1);
        end else begin
          dp_d  = dm_q;
          dm_d  = dp_q;
          run_d = '0;
        end
      end
      OP_STUFF: begin
        dp_d  = dm_q;
        dm_d  = dp_q;
        run_d = '0;
      end
      OP_SE0: begin
        dp_d = 1'b0;
        dm_d = 1'b0;
      end
      OP_IDLE: begin
        dp_d = 1'b0;
        dm_d = 1'b1;
      end
      OP_RELEASE: begin
        oe_d = 1'b0;
        dp_d = 1'b0;
        dm_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q  <= 1'b0;
      dm_q  <= 1'b0;
      oe_q  <= 1'b0;
      run_q <= '0;
    end else begin
      dp_q  <= dp_d;
      dm_q  <= dm_d;
      oe_q  <= oe_d;
      run_q <= run_d;
    end
  end

  assign stuff_due_o = (run_q == RUN_W'(STUFF_RUN));
  assign dp_o        = dp_q;
  assign dm_o        = dm_q;
  assign oe_o        = oe_q;

  // R4: a data bit is never sent while a stuffed bit is owed
  p_no_data_when_stuff_due_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DATA) |-> (run_q < RUN_W'(STUFF_RUN)));

  // R10: line is held between ticks while driven
  p_hold_between_ticks_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && !$past(tick_i)) |-> $stable({dp_q, dm_q}));

endmodule

// File: rtl/usb_ls_tx_ctrl.sv
module usb_ls_tx_ctrl
  import usb_ls_tx_pkg::*;
#(
  parameter int MAX_BYTES = 12,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              stuff_due_i,
  output logic [LEN_W-1:0]  rd_addr_o,
  output line_op_e          op_o,
  output logic              bit_o,
  output logic              commit_o,
  output logic              done_o
);

  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  tx_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] byte_q, byte_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             all_q, all_d;
  logic             done_q, done_d;
  logic             len_ok;
  logic [LEN_W-1:0] last_byte;

  assign len_ok    = (len_i >= LEN_W'(2)) && (len_i <= LEN_W'(MAX_BYTES));
  assign last_byte = len_q - LEN_W'(1);

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    all_d    = all_q;
    done_d   = 1'b0;
    commit_o = 1'b0;
    op_o     = OP_NONE;
    bit_o    = rd_data_i[bit_q];
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && len_ok) begin
          state_d = ST_BITS;
          len_d   = len_i;
          byte_d  = '0;
          bit_d   = '0;
          all_d   = 1'b0;
          op_o    = OP_ACQUIRE;
        end
      end
      ST_BITS: begin
        if (tick_i) begin
          if (stuff_due_i) begin
            op_o = OP_STUFF;
          end else if (all_q) begin
            op_o    = OP_SE0;
            state_d = ST_SE0A;
          end else begin
            op_o = OP_DATA;
            if (bit_q == LAST_BIT) begin
              bit_d = '0;
              if (byte_q == last_byte) all_d  = 1'b1;
              else                     byte_d = byte_q + LEN_W'(1);
            end else begin
              bit_d = bit_q + BIT_W'(1);
            end
          end
        end
      end
      ST_SE0A: begin
        if (tick_i) state_d = ST_SE0B;
      end
      ST_SE0B: begin
        if (tick_i) begin
          op_o    = OP_IDLE;
          state_d = ST_IDLEJ;
        end
      end
      ST_IDLEJ: begin
        if (tick_i) begin
          op_o     = OP_RELEASE;
          done_d   = 1'b1;
          commit_o = (len_q > LEN_W'(2));
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
      all_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      all_q   <= all_d;
      done_q  <= done_d;
    end
  end

  assign rd_addr_o = byte_q;
  assign done_o    = done_q;

  // R8: the latched count cannot move once a packet is running
  p_busy_keeps_len_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(len_q));

  // R9: an out-of-range or absent request keeps the sequencer idle
  p_bad_len_stays_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(start_i && len_ok)) |=> (state_q == ST_IDLE));

  // R3: byte address stays inside the packet
  p_addr_in_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BITS) |-> (byte_q < len_q));

endmodule

// File: rtl/usb_ls_tx_addr.sv
module usb_ls_tx_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] dev_addr_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (commit_i) addr_d = new_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign dev_addr_o = addr_q;

  // R7: the active address only moves on a commit
  p_addr_moves_on_commit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(commit_i));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int MAX_BYTES = 12,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int STUFF_RUN = 6,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tick_i,
  output logic [LEN_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  line_op_e op;
  logic     bit_val;
  logic     stuff_due;
  logic     commit;

  usb_ls_tx_ctrl #(
    .MAX_BYTES (MAX_BYTES),
    .BYTE_W    (BYTE_W),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .tick_i      (tick_i),
    .rd_data_i   (rd_data_i),
    .stuff_due_i (stuff_due),
    .rd_addr_o   (rd_addr_o),
    .op_o        (op),
    .bit_o       (bit_val),
    .commit_o    (commit),
    .done_o      (done_o)
  );

  usb_ls_tx_line #(
    .STUFF_RUN (STUFF_RUN)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick_i      (tick_i),
    .op_i        (op),
    .bit_i       (bit_val),
    .stuff_due_o (stuff_due),
    .dp_o        (dp_o),
    .dm_o        (dm_o),
    .oe_o        (oe_o)
  );

  usb_ls_tx_addr #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .commit_i   (commit),
    .new_addr_i (new_addr_i),
    .dev_addr_o (dev_addr_o)
  );

  // R6: drivers drop exactly when done fires
  p_release_with_done_r6 : assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(oe_o) |-> done_o);

  // R6: done is a single-clock pulse
  p_done_single_r6 : assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |=> !done_o);

  // R5: undriven lines rest at zero
  p_idle_lines_low_r5 : assert property (@(posedge clk) disable iff (!rst_core_n)
    !oe_o |-> (!dp_o && !dm_o));

endmodule

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] len_i;
  logic       tick_i;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic [6:0] new_addr_i;
  logic       dp_o, dm_o, oe_o, done_o;
  logic [6:0] dev_addr_o;

  logic [7:0] buf_mem [16];
  logic [1:0] exp_sym [256];
  int         exp_n;
  int         n_checks;
  int         n_errors;
  logic [6:0] exp_addr;
  bit         timed_out;

  assign rd_data_i = buf_mem[rd_addr_o];

  usb_ls_tx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_i      (len_i),
    .tick_i     (tick_i),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .new_addr_i (new_addr_i),
    .dp_o       (dp_o),
    .dm_o       (dm_o),
    .oe_o       (oe_o),
    .done_o     (done_o),
    .dev_addr_o (dev_addr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bit-rate enable: one clock high out of four, changed just after posedge
  initial begin
    tick_i = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      #2 tick_i = 1'b1;
      @(posedge clk);
      #2 tick_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // independent model: NRZI with bit stuffing, then SE0 SE0 J
  task automatic build_expected(input int len);
    logic [1:0] line;
    int run;
    line  = 2'b01;
    run   = 0;
    exp_n = 0;
    for (int i = 0; i < len; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (run == 6) begin
          line = ~line;
          run  = 0;
          exp_sym[exp_n++] = line;
        end
        if (buf_mem[i][j]) run++;
        else begin
          line = ~line;
          run  = 0;
        end
        exp_sym[exp_n++] = line;
      end
    end
    if (run == 6) begin
      line = ~line;
      exp_sym[exp_n++] = line;
    end
    exp_sym[exp_n++] = 2'b00;
    exp_sym[exp_n++] = 2'b00;
    exp_sym[exp_n++] = 2'b01;
  endtask

  task automatic run_packet(input int len, input logic [6:0] naddr, input bit poke);
    logic [1:0] prev;
    bit held;
    build_expected(len);
    new_addr_i = naddr;
    @(negedge clk);
    len_i   = 4'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(oe_o === 1'b1 && {dp_o, dm_o} === 2'b01, "R2 acquire J",
        {oe_o, dp_o, dm_o}, 3'b101);
    prev = {dp_o, dm_o};
    for (int k = 0; k < exp_n; k++) begin
      held = 1'b1;
      while (tick_i !== 1'b1) begin
        @(negedge clk);
        if (tick_i !== 1'b1 && {dp_o, dm_o} !== prev) held = 1'b0;
      end
      @(negedge clk);
      if (poke && k == 5) begin
        len_i   = 4'd12;
        start_i = 1'b1;
      end
      if (!held) chk(1'b0, "R10 line moved between ticks", {dp_o, dm_o}, prev);
      chk({dp_o, dm_o} === exp_sym[k] && oe_o === 1'b1,
          (k >= exp_n - 3) ? "R5 end of packet" : "R3/R4 wire symbol",
          {oe_o, dp_o, dm_o}, {1'b1, exp_sym[k]});
      prev = {dp_o, dm_o};
      if (poke && k == 5) begin
        @(negedge clk);
        start_i = 1'b0;
        prev = {dp_o, dm_o};
      end
    end
    while (tick_i !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(oe_o === 1'b0 && dp_o === 1'b0 && dm_o === 1'b0, "R5 release",
        {oe_o, dp_o, dm_o}, 3'b000);
    chk(done_o === 1'b1, "R6 done on release", done_o, 1'b1);
    if (len > 2) exp_addr = naddr;
    chk(dev_addr_o === exp_addr, "R7 address commit", dev_addr_o, exp_addr);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done one clock", done_o, 1'b0);
  endtask

  task automatic t_reset;
    chk(oe_o === 1'b0 && dp_o === 1'b0 && dm_o === 1'b0, "R1 lines at reset",
        {oe_o, dp_o, dm_o}, 3'b000);
    chk(done_o === 1'b0, "R1 done at reset", done_o, 1'b0);
    chk(dev_addr_o === 7'd0, "R1 address at reset", dev_addr_o, 7'd0);
  endtask

  task automatic t_handshake;
    buf_mem[0] = 8'h80;
    buf_mem[1] = 8'hD2;
    run_packet(2, 7'h55, 1'b0);   // R7: 2-byte packet keeps the address
  endtask

  task automatic t_data;
    buf_mem[0] = 8'h80;
    buf_mem[1] = 8'hC3;
    buf_mem[2] = 8'hA5;
    run_packet(3, 7'h2A, 1'b0);   // R7: data packet commits
    buf_mem[1] = 8'h4B;
    run_packet(2, 7'h11, 1'b0);   // R7: handshake after it leaves 0x2A
  endtask

  task automatic t_stuffing;
    // R4: long runs of ones, and a run of six ending on the last bit
    buf_mem[0] = 8'h80;
    buf_mem[1] = 8'hFF;
    buf_mem[2] = 8'hFF;
    buf_mem[3] = 8'hFC;
    run_packet(4, 7'h33, 1'b0);
    buf_mem[1] = 8'hFC;
    run_packet(2, 7'h01, 1'b0);
  endtask

  task automatic t_full_length;
    // R3: twelve bytes of mixed patterns
    buf_mem[0] = 8'h80;
    for (int i = 1; i < 12; i++) buf_mem[i] = 8'((i * 37) ^ 8'h6E);
    run_packet(12, 7'h7F, 1'b0);
  endtask

  task automatic t_busy;
    // R8: start during a packet is dropped
    buf_mem[0] = 8'h80;
    buf_mem[1] = 8'h3F;
    buf_mem[2] = 8'h01;
    run_packet(3, 7'h0C, 1'b1);
    repeat (24) begin
      @(negedge clk);
      chk(oe_o === 1'b0 && done_o === 1'b0, "R8 no second packet",
          {oe_o, done_o}, 2'b00);
    end
  endtask

  task automatic t_bad_len;
    // R9: counts 1, 0 and 13 are refused
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      len_i   = (t == 0) ? 4'd1 : (t == 1) ? 4'd0 : 4'd13;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (12) begin
        chk(oe_o === 1'b0 && done_o === 1'b0, "R9 bad count ignored",
            {oe_o, done_o}, 2'b00);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    n_checks   = 0;
    n_errors   = 0;
    exp_addr   = 7'd0;
    timed_out  = 1'b0;
    start_i    = 1'b0;
    len_i      = 4'd0;
    new_addr_i = 7'd0;
    for (int i = 0; i < 16; i++) buf_mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      begin
        t_reset();
        t_handshake();
        t_data();
        t_stuffing();
        t_full_length();
        t_busy();
        t_bad_len();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule